// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Converters

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out. It has no clock and no state. The operand bits are split into five slices. From least to most significant, the slices are 2, 2, 3, 4 and 5 bits wide. The lowest slice is a plain ripple adder that takes the external carry-in.

Each upper slice precomputes its result as if its incoming carry were zero, using a ripple adder. It then obtains the result for an incoming carry of one by incrementing that value. The incrementer takes the slice sum together with its carry, a word of width+1 bits. This costs far fewer gates than a second ripple adder. A 2:1 select, steered by the carry coming out of the slice below, picks between the two candidates. The carry selected in the top slice is the adder's carry-out.

A parameter swaps every incrementer for a second ripple adder whose carry-in is tied high. This gives a conventional dual-adder form for comparison. Both forms must give identical results.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals a + b + cin, computed as a 17-bit unsigned value.
- R2: The carry entering each upper slice equals the carry out of the lower bits below it, and it is propagated correctly. The upper slices start at bit positions 2, 4, 7 and 11.
- R3: A carry propagates from cin through every slice. With a = 16'hFFFF, b = 0 and cin = 1, the result is sum = 0 and cout = 1. Each slice's incremented candidate wraps to zero with a carry.
- R4: With a = b = 16'hFFFF and cin = 1, the result is sum = 16'hFFFF and cout = 1.
- R5: With a = b = 0, the result is sum equal to cin zero-extended to 16 bits, and cout = 0.
- R6: With b = ~a, cin = 0 gives sum = 16'hFFFF and cout = 0, and cin = 1 gives sum = 0 and cout = 1.
- R7: The incrementer form (DUAL_RCA = 0) and the dual ripple form (DUAL_RCA = 1) give the same sum and cout for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Zero operands and complementary operands test the two extremes of the select path. Zero operands mean no slice ever selects its incremented candidate. Complementary operands make every slice purely propagating, so cin alone decides every select. Walking a long propagate run up to each slice boundary, with and without a carry-in, shows whether each select line is wired to the right lower carry. Placing a single generate pair just below each boundary separates a carry that is generated from one that is propagated. Random operands with random carry-in are then applied to both the incrementer form and the dual ripple form at once. This catches any disagreement between the two forms, or with the arithmetic reference.

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder #(
  parameter bit DUAL_RCA = 1'b0
) (
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        cin,
  output logic [15:0] sum,
  output logic        cout
);
  localparam int NG = 5;

  function automatic int gw(input int i);
    case (i)
      0, 1:    return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int glo(input int i);
    int s = 0;
    for (int j = 0; j < i; j++) s += gw(j);
    return s;
  endfunction

  logic [NG:0] gc;
  assign gc[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : grp
    localparam int W  = gw(g);
    localparam int LO = glo(g);

    logic [W:0]   c0;
    logic [W-1:0] s0;
    assign c0[0] = (g == 0) ? cin : 1'b0;

    for (genvar k = 0; k < W; k++) begin : fa0
      assign s0[k]   = a[LO+k] ^ b[LO+k] ^ c0[k];
      assign c0[k+1] = (a[LO+k] & b[LO+k]) | (c0[k] & (a[LO+k] ^ b[LO+k]));
    end

    if (g == 0) begin : base
      assign sum[LO +: W] = s0;
      assign gc[g+1]      = c0[W];
    end else begin : sel
      logic [W:0] r0, r1, r;
      assign r0 = {c0[W], s0};

      if (DUAL_RCA) begin : rca1
        logic [W:0]   c1;
        logic [W-1:0] s1;
        assign c1[0] = 1'b1;
        for (genvar k = 0; k < W; k++) begin : fa1
          assign s1[k]   = a[LO+k] ^ b[LO+k] ^ c1[k];
          assign c1[k+1] = (a[LO+k] & b[LO+k]) | (c1[k] & (a[LO+k] ^ b[LO+k]));
        end
        assign r1 = {c1[W], s1};
      end else begin : inc
        logic [W:0] p;
        assign p[0] = 1'b1;
        for (genvar k = 0; k <= W; k++) begin : bit_
          assign r1[k] = r0[k] ^ p[k];
          if (k < W) begin : chain
            assign p[k+1] = p[k] & r0[k];
          end
        end
      end

      assign r            = gc[g] ? r1 : r0;
      assign sum[LO +: W] = r[W-1:0];
      assign gc[g+1]      = r[W];
    end
  end

  assign cout = gc[NG];
endmodule

// File: rtl/csel_sqrt_adder_chk.sv
module csel_sqrt_adder_chk (
  input logic [15:0] a,
  input logic [15:0] b,
  input logic        cin,
  input logic [15:0] sum,
  input logic        cout,
  input logic [5:0]  gc
);
  localparam int BOUND [5] = '{0, 2, 4, 7, 11};

  always_comb begin
    if (!$isunknown({a, b, cin, sum, cout, gc})) begin
      a_r1_sum: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + {16'b0, cin})
        else $error("R1 sum mismatch");
      for (int k = 1; k < 5; k++) begin
        logic [16:0] msk, t;
        msk = (17'h1 << BOUND[k]) - 17'h1;
        t   = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {16'b0, cin};
        a_r2_slice_carry: assert (gc[k] == t[BOUND[k]])
          else $error("R2 carry into slice %0d wrong", k);
      end
      if (a == 16'hFFFF && b == 16'h0 && cin)
        a_r3_full_ripple: assert (sum == 16'h0 && cout) else $error("R3");
      if (a == 16'hFFFF && b == 16'hFFFF && cin)
        a_r4_max: assert (sum == 16'hFFFF && cout) else $error("R4");
      if (a == 16'h0 && b == 16'h0)
        a_r5_zero: assert (sum == {15'b0, cin} && !cout) else $error("R5");
      if (b == ~a)
        a_r6_compl: assert (sum == {16{~cin}} && cout == cin) else $error("R6");
    end
  end
endmodule

bind csel_sqrt_adder csel_sqrt_adder_chk u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .gc(gc)
);

// File: tb/tb_csel_sqrt_adder.sv
module tb_csel_sqrt_adder;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND      = 100000;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a, b, s_inc, s_rca;
  logic        cin, co_inc, co_rca;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  csel_sqrt_adder #(.DUAL_RCA(1'b0)) dut (
    .a(a), .b(b), .cin(cin), .sum(s_inc), .cout(co_inc));
  csel_sqrt_adder #(.DUAL_RCA(1'b1)) dut_rca (
    .a(a), .b(b), .cin(cin), .sum(s_rca), .cout(co_rca));

  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {16'b0, c};
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input string req);
    logic [16:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk);
    #1;
    exp = ref_add(x, y, c);
    checks++;
    if ({co_inc, s_inc} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, x, y, c,
               {co_inc, s_inc}, exp);
    end
    checks++;
    if ({co_rca, s_rca} !== {co_inc, s_inc}) begin
      errors++;
      $display("FAIL R7 a=%h b=%h cin=%b actual=%h expected=%h", x, y, c,
               {co_rca, s_rca}, {co_inc, s_inc});
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    apply(16'h0, 16'h0, 1'b0, "R5");
    apply(16'h0, 16'h0, 1'b1, "R5");
    apply(16'hFFFF, 16'h0, 1'b1, "R3");
    apply(16'h0, 16'hFFFF, 1'b1, "R3");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R1");
    apply(16'hAAAA, 16'h5555, 1'b0, "R6");
    apply(16'hAAAA, 16'h5555, 1'b1, "R6");
    apply(16'h1234, 16'hEDCB, 1'b1, "R6");
    apply(16'h5555, 16'h5555, 1'b1, "R1");
    apply(16'hAAAA, 16'hAAAA, 1'b0, "R1");
    foreach (dut.u_chk.BOUND[k]) begin
      if (k > 0) begin
        int lo = dut.u_chk.BOUND[k];
        logic [15:0] run = 16'((32'h1 << lo) - 1);
        logic [15:0] top = 16'(32'h1 << (lo - 1));
        apply(run, 16'h0, 1'b1, "R2");
        apply(run, 16'h0, 1'b0, "R2");
        apply(top, top, 1'b0, "R2");
        apply(run ^ 16'hFFFF, run, 1'b1, "R2");
      end
    end
    void'($urandom(32'd20240517));
    for (int i = 0; i < NRAND; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG + NRAND/2) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule